// File: doc/BRIEF.md
# Synthesizer Lock/Unlock Interrupt Manager

This block sits beside a fractional-N frequency synthesizer. It turns lock-detector transitions and calibration and retune events into two status bits, lock and unlock. The two bits exclude each other, and each stays set until software reads and clears it. A per-bit enable mask drives a single interrupt line.

When the radio deliberately steps its synthesizer between the receive frequency and the transmit frequency, which is 1 MHz higher, the detector may glitch. A hop timer masks detector transitions for the duration of that step. The step to transmit and the step back to receive have separately parameterized lengths.

The block also tells the transceiver controller what to do. An unlock during a transmission requests an abort back to the synthesizer-on state. An unlock during a reception arms a return-to-listen request, which fires once lock comes back.

Top module: `pll_irq_mgr`

## Requirements
- R1: While `rst` is high at a clock edge, every output goes to 0 at that edge.
- R2: A lock event sets `lock_flag` and clears `unlock_flag` at the next edge. A lock event is either a 0-to-1 transition of `lock_det` that is accepted, or a `cal_done` pulse. A detector transition is accepted when `synth_on` is 1 and no hop window is open.
- R3: An unlock event sets `unlock_flag` and clears `lock_flag` at the next edge. An unlock event is either an accepted 1-to-0 transition of `lock_det`, or a `cal_start` or `freq_chg` pulse while `trx_state` is 1, 2 or 3. In any other state, `cal_start` and `freq_chg` have no effect.
- R4: When a lock event and an unlock event occur in the same cycle, the unlock event wins.
- R5: `rd_clr` clears both flags at the next edge, unless a lock or unlock event occurs in the same cycle. In that case the event decides the flags.
- R6: `irq` is 1 exactly when (`lock_flag` and `irq_mask[0]`) or (`unlock_flag` and `irq_mask[1]`). The flag values are those updated at the same edge; the mask value is the one sampled at that edge.
- R7: A `hop_req` pulse opens a hop window starting at the next edge. The window lasts TX_HOP_CYC cycles when `hop_to_tx` is 1 and RX_HOP_CYC cycles when it is 0. `hop_active` is high exactly during the window. A new request restarts the window.
- R8: A detector transition in the cycle of a `hop_req`, or while `hop_active` is high, changes no flag. `cal_done`, `cal_start` and `freq_chg` still act during the window.
- R9: An unlock event while `trx_state` is 4 (transmitting) or 5 (transmitting with retry) gives a one-cycle `abort_tx` pulse at the next edge.
- R10: An unlock event in state 6 (receiving) or 7 (receiving with auto-acknowledge) arms a return request. A later lock event, in a cycle with no unlock event and while the state is still 6 or 7, gives a one-cycle `resume_listen` pulse at the next edge and disarms the request. `resume_ack` is high with that pulse only if the state was 7. Leaving states 6 and 7 disarms the request.
- R11: While `synth_on` is 0, `lock_det` transitions have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| synth_on | input | 1 | Synthesizer enabled; qualifies detector transitions |
| lock_det | input | 1 | Raw lock detector level |
| cal_start | input | 1 | Manual centre-frequency calibration start pulse |
| cal_done | input | 1 | Calibration complete pulse |
| freq_chg | input | 1 | Frequency setting changed pulse |
| hop_req | input | 1 | Start of a receive/transmit frequency step |
| hop_to_tx | input | 1 | Step direction: 1 toward transmit, 0 back to receive |
| trx_state | input | 3 | Transceiver state: 0 off, 1 synth on, 2 listen, 3 listen with ack, 4 send, 5 send with retry, 6 receive, 7 receive with ack |
| irq_mask | input | 2 | Bit 0 enables lock, bit 1 enables unlock onto irq |
| rd_clr | input | 1 | Read-and-clear strobe for both flags |
| lock_flag | output | 1 | Sticky lock status |
| unlock_flag | output | 1 | Sticky unlock status |
| irq | output | 1 | Masked interrupt line |
| hop_active | output | 1 | Hop window open |
| abort_tx | output | 1 | Request to stop transmission |
| resume_listen | output | 1 | Request to return to listening |
| resume_ack | output | 1 | Return target is the auto-acknowledge listening state |

## Verification
A hop counter left with the wrong count shows at the ports in two ways. `hop_active` falls too early or too late, and a detector transition near the end of the window either moves a flag or fails to move it. Both show up within one cycle of the window's true end. A stale return-request arm shows only later, as a spurious or missing `resume_listen` on the next lock event. For that reason the bench relocks in several receive states. Flag-priority mistakes show one edge after the colliding events, on both flags and on `irq` together.

// File: rtl/pll_irq_pkg.sv
package pll_irq_pkg;
  typedef enum logic [2:0] {
    TRX_OFF        = 3'd0,
    TRX_SYNTH      = 3'd1,
    TRX_LISTEN     = 3'd2,
    TRX_LISTEN_ACK = 3'd3,
    TRX_SEND       = 3'd4,
    TRX_SEND_RETRY = 3'd5,
    TRX_RECV       = 3'd6,
    TRX_RECV_ACK   = 3'd7
  } trx_state_e;

  function automatic logic st_idle_on(trx_state_e s);
    return (s == TRX_SYNTH) || (s == TRX_LISTEN) || (s == TRX_LISTEN_ACK);
  endfunction

  function automatic logic st_sending(trx_state_e s);
    return (s == TRX_SEND) || (s == TRX_SEND_RETRY);
  endfunction

  function automatic logic st_receiving(trx_state_e s);
    return (s == TRX_RECV) || (s == TRX_RECV_ACK);
  endfunction
endpackage

// File: rtl/pll_hop_timer.sv
module pll_hop_timer #(
  parameter int TX_HOP_CYC = 4000,
  parameter int RX_HOP_CYC = 8000
) (
  input  logic clk,
  input  logic rst,
  input  logic hop_req,
  input  logic hop_to_tx,
  output logic hop_active
);
  localparam int MAX_CYC = (TX_HOP_CYC > RX_HOP_CYC) ? TX_HOP_CYC : RX_HOP_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] TX_LOAD = CW'(TX_HOP_CYC);
  localparam logic [CW-1:0] RX_LOAD = CW'(RX_HOP_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (hop_req)       cnt_q <= hop_to_tx ? TX_LOAD : RX_LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign hop_active = (cnt_q != '0);

  a_r7_opens: assert property (@(posedge clk) disable iff (rst)
    hop_req |=> hop_active);
  a_r7_no_self_start: assert property (@(posedge clk) disable iff (rst)
    (!hop_req && !hop_active) |=> !hop_active);
endmodule

// File: rtl/pll_irq_flags.sv
module pll_irq_flags #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lock_evt,
  input  logic            unlock_evt,
  input  logic            rd_clr,
  input  logic [NSRC-1:0] irq_mask,
  output logic            lock_flag,
  output logic            unlock_flag,
  output logic            irq
);
  logic lock_d, unlock_d;
  logic [NSRC-1:0] src_d;

  always_comb begin
    lock_d   = lock_flag;
    unlock_d = unlock_flag;
    if (unlock_evt) begin
      unlock_d = 1'b1;
      lock_d   = 1'b0;
    end else if (lock_evt) begin
      lock_d   = 1'b1;
      unlock_d = 1'b0;
    end else if (rd_clr) begin
      lock_d   = 1'b0;
      unlock_d = 1'b0;
    end
  end

  always_comb begin
    src_d    = '0;
    src_d[0] = lock_d;
    src_d[1] = unlock_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_flag   <= 1'b0;
      unlock_flag <= 1'b0;
      irq         <= 1'b0;
    end else begin
      lock_flag   <= lock_d;
      unlock_flag <= unlock_d;
      irq         <= |(src_d & irq_mask);
    end
  end

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!lock_flag && !unlock_flag && !irq));
  a_r4_unlock_wins: assert property (@(posedge clk) disable iff (rst)
    unlock_evt |=> (unlock_flag && !lock_flag));
  a_r2_lock_sets: assert property (@(posedge clk) disable iff (rst)
    (lock_evt && !unlock_evt) |=> (lock_flag && !unlock_flag));
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !lock_evt && !unlock_evt) |=> (!lock_flag && !unlock_flag));
  a_r6_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> (lock_flag || unlock_flag));
endmodule

// File: rtl/pll_trx_action.sv
module pll_trx_action
  import pll_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  trx_state_e state,
  input  logic       lock_evt,
  input  logic       unlock_evt,
  output logic       abort_tx,
  output logic       resume_listen,
  output logic       resume_ack
);
  logic arm_q;
  logic fire;

  assign fire = lock_evt && !unlock_evt && arm_q && st_receiving(state);

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q         <= 1'b0;
      abort_tx      <= 1'b0;
      resume_listen <= 1'b0;
      resume_ack    <= 1'b0;
    end else begin
      if (!st_receiving(state)) arm_q <= 1'b0;
      else if (unlock_evt)      arm_q <= 1'b1;
      else if (lock_evt)        arm_q <= 1'b0;
      abort_tx      <= unlock_evt && st_sending(state);
      resume_listen <= fire;
      resume_ack    <= fire && (state == TRX_RECV_ACK);
    end
  end

  a_r9_abort_src: assert property (@(posedge clk) disable iff (rst)
    abort_tx |-> st_sending($past(state)));
  a_r10_resume_armed: assert property (@(posedge clk) disable iff (rst)
    resume_listen |-> ($past(arm_q) && st_receiving($past(state))));
  a_r10_ack_with_resume: assert property (@(posedge clk) disable iff (rst)
    resume_ack |-> resume_listen);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    resume_listen |=> !resume_listen);
endmodule

// File: rtl/pll_irq_mgr.sv
module pll_irq_mgr
  import pll_irq_pkg::*;
#(
  parameter int TX_HOP_CYC = 4000,
  parameter int RX_HOP_CYC = 8000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       synth_on,
  input  logic       lock_det,
  input  logic       cal_start,
  input  logic       cal_done,
  input  logic       freq_chg,
  input  logic       hop_req,
  input  logic       hop_to_tx,
  input  logic [2:0] trx_state,
  input  logic [1:0] irq_mask,
  input  logic       rd_clr,
  output logic       lock_flag,
  output logic       unlock_flag,
  output logic       irq,
  output logic       hop_active,
  output logic       abort_tx,
  output logic       resume_listen,
  output logic       resume_ack
);
  trx_state_e st;
  logic det_q, det_rise, det_fall, det_ok, lock_evt, unlock_evt;

  assign st = trx_state_e'(trx_state);

  always_ff @(posedge clk) begin
    if (rst) det_q <= 1'b0;
    else     det_q <= lock_det;
  end

  assign det_rise   = lock_det && !det_q;
  assign det_fall   = !lock_det && det_q;
  assign det_ok     = synth_on && !hop_req && !hop_active;
  assign lock_evt   = (det_rise && det_ok) || cal_done;
  assign unlock_evt = (det_fall && det_ok) || ((cal_start || freq_chg) && st_idle_on(st));

  pll_hop_timer #(.TX_HOP_CYC(TX_HOP_CYC), .RX_HOP_CYC(RX_HOP_CYC)) u_hop (
    .clk(clk), .rst(rst), .hop_req(hop_req), .hop_to_tx(hop_to_tx),
    .hop_active(hop_active));

  pll_irq_flags #(.NSRC(2)) u_flags (
    .clk(clk), .rst(rst), .lock_evt(lock_evt), .unlock_evt(unlock_evt),
    .rd_clr(rd_clr), .irq_mask(irq_mask), .lock_flag(lock_flag),
    .unlock_flag(unlock_flag), .irq(irq));

  pll_trx_action u_act (
    .clk(clk), .rst(rst), .state(st), .lock_evt(lock_evt),
    .unlock_evt(unlock_evt), .abort_tx(abort_tx),
    .resume_listen(resume_listen), .resume_ack(resume_ack));

  a_r8_hop_quiet: assert property (@(posedge clk) disable iff (rst)
    ((hop_req || hop_active) && !cal_done && !cal_start && !freq_chg && !rd_clr)
      |=> ($stable(lock_flag) && $stable(unlock_flag)));
  a_r11_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (!synth_on && !cal_done && !cal_start && !freq_chg && !rd_clr)
      |=> ($stable(lock_flag) && $stable(unlock_flag)));
  a_r3_cal_start_unlocks: assert property (@(posedge clk) disable iff (rst)
    (cal_start && st_idle_on(st)) |=> (unlock_flag && !lock_flag));
endmodule

// File: tb/pll_irq_mgr_test.sv
module pll_irq_mgr_test;
  localparam int TXC = 5;
  localparam int RXC = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic synth_on = 0, lock_det = 0, cal_start = 0, cal_done = 0, freq_chg = 0;
  logic hop_req = 0, hop_to_tx = 0, rd_clr = 0;
  logic [2:0] trx_state = 3'd1;
  logic [1:0] irq_mask = 2'b11;
  logic lock_flag, unlock_flag, irq, hop_active, abort_tx, resume_listen, resume_ack;

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit done = 0;

  // reference model state
  bit m_lq, m_lf, m_uf, m_irq, m_arm, m_abort, m_res, m_rack;
  int m_cnt;

  always #2 clk = ~clk;

  pll_irq_mgr #(.TX_HOP_CYC(TXC), .RX_HOP_CYC(RXC)) uut (
    .clk(clk), .rst(rst), .synth_on(synth_on), .lock_det(lock_det),
    .cal_start(cal_start), .cal_done(cal_done), .freq_chg(freq_chg),
    .hop_req(hop_req), .hop_to_tx(hop_to_tx), .trx_state(trx_state),
    .irq_mask(irq_mask), .rd_clr(rd_clr), .lock_flag(lock_flag),
    .unlock_flag(unlock_flag), .irq(irq), .hop_active(hop_active),
    .abort_tx(abort_tx), .resume_listen(resume_listen), .resume_ack(resume_ack));

  always @(posedge clk) begin
    bit rise, fall, ok, le, ue, idle, btx, brx, act;
    if (rst) begin
      m_lq = 0; m_lf = 0; m_uf = 0; m_irq = 0; m_arm = 0;
      m_abort = 0; m_res = 0; m_rack = 0; m_cnt = 0;
    end else begin
      act  = (m_cnt > 0);
      rise = lock_det && !m_lq;
      fall = !lock_det && m_lq;
      ok   = synth_on && !hop_req && !act;
      idle = (trx_state >= 1) && (trx_state <= 3);
      btx  = (trx_state == 4) || (trx_state == 5);
      brx  = (trx_state == 6) || (trx_state == 7);
      le   = (rise && ok) || cal_done;
      ue   = (fall && ok) || ((cal_start || freq_chg) && idle);
      if (ue) begin m_uf = 1; m_lf = 0; end
      else if (le) begin m_lf = 1; m_uf = 0; end
      else if (rd_clr) begin m_lf = 0; m_uf = 0; end
      m_irq   = (m_lf && irq_mask[0]) || (m_uf && irq_mask[1]);
      m_abort = ue && btx;
      m_res   = le && !ue && m_arm && brx;
      m_rack  = m_res && (trx_state == 7);
      if (!brx) m_arm = 0;
      else if (ue) m_arm = 1;
      else if (le) m_arm = 0;
      if (hop_req) m_cnt = hop_to_tx ? TXC : RXC;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_lq = lock_det;
    end
  end

  task automatic cmp1(string sig, logic act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, sig, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      cmp1("lock_flag", lock_flag, m_lf);
      cmp1("unlock_flag", unlock_flag, m_uf);
      cmp1("irq", irq, m_irq);
      cmp1("hop_active", hop_active, m_cnt > 0);
      cmp1("abort_tx", abort_tx, m_abort);
      cmp1("resume_listen", resume_listen, m_res);
      cmp1("resume_ack", resume_ack, m_rack);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1; tick(); s = 0; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tag = "R1"; rst = 1; lock_det = 1; cal_done = 1; tick(3);
    rst = 0; cal_done = 0; lock_det = 0; synth_on = 1; tick(2);

    tag = "R2"; lock_det = 1; tick(2); pulse(cal_done);
    tag = "R3"; lock_det = 0; tick(2); pulse(rd_clr);
    trx_state = 1; pulse(freq_chg); pulse(cal_done); pulse(cal_start);
    trx_state = 0; pulse(rd_clr); pulse(freq_chg); pulse(cal_start);
    trx_state = 4; pulse(freq_chg);
    tag = "R4"; trx_state = 2; lock_det = 1; freq_chg = 1; cal_done = 1; tick();
    freq_chg = 0; cal_done = 0; tick(2);
    tag = "R5"; pulse(rd_clr); pulse(cal_done);
    rd_clr = 1; cal_done = 1; tick(); rd_clr = 0; cal_done = 0; tick();
    trx_state = 1; rd_clr = 1; cal_start = 1; tick(); rd_clr = 0; cal_start = 0; tick();
    tag = "R6";
    for (int m = 0; m < 4; m++) begin
      irq_mask = 2'(m); pulse(cal_done); pulse(cal_start); pulse(rd_clr);
    end
    irq_mask = 2'b11;

    tag = "R7"; hop_to_tx = 1; pulse(hop_req); tick(TXC + 2);
    hop_to_tx = 0; pulse(hop_req); tick(RXC + 2);
    hop_to_tx = 1; pulse(hop_req); tick(2); hop_to_tx = 0; pulse(hop_req); tick(RXC + 2);
    tag = "R8"; pulse(cal_done);
    hop_to_tx = 1; hop_req = 1; lock_det = 0; tick(); hop_req = 0;
    for (int i = 0; i < TXC; i++) begin lock_det = ~lock_det; tick(); end
    lock_det = 1; tick(2); lock_det = 0; tick(2);
    hop_to_tx = 0; pulse(hop_req); pulse(cal_done); lock_det = 1; tick(); pulse(freq_chg);
    tick(RXC);

    tag = "R9"; lock_det = 1; tick(2);
    trx_state = 4; lock_det = 0; tick(2); lock_det = 1; tick(2);
    trx_state = 5; lock_det = 0; tick(2); lock_det = 1; tick(2);
    trx_state = 5; pulse(cal_start);

    tag = "R10"; trx_state = 6; lock_det = 0; tick(3); lock_det = 1; tick(3);
    trx_state = 7; lock_det = 0; tick(3); lock_det = 1; tick(3);
    trx_state = 7; lock_det = 0; tick(2); trx_state = 2; tick(); trx_state = 7; lock_det = 1; tick(3);
    trx_state = 6; pulse(cal_done); lock_det = 0; tick(); pulse(cal_done);

    tag = "R11"; synth_on = 0; lock_det = 1; tick(2); lock_det = 0; tick(2);
    lock_det = 1; tick(); synth_on = 1; tick(3);

    tag = "R2/R3 mixed";
    for (int i = 0; i < 600; i++) begin
      synth_on  = ($urandom_range(0, 9) != 0);
      lock_det  = ($urandom_range(0, 3) == 0) ? ~lock_det : lock_det;
      cal_start = ($urandom_range(0, 15) == 0);
      cal_done  = ($urandom_range(0, 15) == 0);
      freq_chg  = ($urandom_range(0, 15) == 0);
      hop_req   = ($urandom_range(0, 20) == 0);
      hop_to_tx = $urandom_range(0, 1);
      rd_clr    = ($urandom_range(0, 7) == 0);
      irq_mask  = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) trx_state = 3'($urandom_range(0, 7));
      tick();
    end
    finish_run();
  end
endmodule